// File: doc/BRIEF.md
# Byte-Level I2C Master with Prioritised Commands

This block is a single-master I2C byte engine. Software steers it through three command fields presented together on one write strobe: an interrupt-flag value, a start-request value and a master-select value. Setting master-select while the block is in slave mode opens a transaction. The block issues a start condition and shifts out the byte on `data_i`, which is normally the address plus the R/W bit. After every byte it samples the acknowledge, raises `int_o` and holds SCL low until software acts again.

While the block waits with SCL held low, software chooses among three actions. Writing 0 to the interrupt flag sends the next byte. Setting the start request produces a repeated start followed by a byte. Clearing master-select produces a stop condition and a return to slave mode. If one write carries more than one of these, a fixed priority decides. Stop wins over repeated start and over next byte. Repeated start wins over next byte.

SCL timing comes from a divider of the system clock. Each bus phase lasts exactly `max(div_i,1)` clock cycles. The user picks `div_i` so that SCL does not exceed 400 kHz. The block assumes it is the only master on the bus and does no arbitration.

Top module: `i2c_cmd_master`

## Requirements
- R1: During reset and afterwards until the first command, scl_o=1, sda_o=1, int_o=0, busy_o=0, msel_o=0 and ack_o=0.
- R2: In slave mode, a write with master-select=1 sets msel_o in the next cycle. The block then makes a start condition (SDA falls while SCL is high) and transmits the byte present on data_i at the write.
- R3: A byte is 8 bits, MSB first, each bit valid on SDA across an SCL high phase. A ninth clock follows with SDA released to 1. Outside start and stop conditions, SDA never changes while SCL stays high.
- R4: The SDA level seen on the ninth SCL high phase is latched on ack_o, where 0 means acknowledged and 1 means not acknowledged.
- R5: When the ninth clock ends, int_o goes to 1 and SCL stays low until a command is accepted.
- R6: While waiting, a write with master-select=1, start=0 and interrupt-flag=0 sends the next data_i byte with no start or stop condition.
- R7: While waiting, a write with master-select=1 and start=1 produces a repeated start and then sends data_i, whatever interrupt-flag value is written. In the repeated start, SDA is released with SCL low, SCL rises, and then SDA falls.
- R8: While waiting, a write with master-select=0 clears msel_o in the next cycle and produces a stop condition (SDA rises while SCL is high) with no byte sent, whatever start and interrupt-flag values are written.
- R9: While waiting, a write with master-select=1, start=0 and interrupt-flag=1 has no effect. int_o stays 1 and the bus stays unchanged.
- R10: Writes are ignored while a byte is on the bus. In slave mode, writes with master-select=0 are ignored.
- R11: Every bus phase, and so every SCL high phase of a data bit, lasts exactly max(div_i,1) clock cycles.
- R12: busy_o is 1 from the cycle after a start command until the stop condition has completed, then returns to 0 with the bus idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_i | input | DIV_W | Phase length in clock cycles (0 treated as 1) |
| wr_i | input | 1 | Command write strobe |
| wr_int_i | input | 1 | Interrupt-flag value written (0 requests next byte) |
| wr_start_i | input | 1 | Start-request value written (1 requests repeated start) |
| wr_msel_i | input | 1 | Master-select value written |
| data_i | input | 8 | Byte to transmit, captured when a command is accepted |
| sda_i | input | 1 | Sensed SDA line level |
| scl_o | output | 1 | SCL drive level (0 pulls low) |
| sda_o | output | 1 | SDA drive level (0 pulls low) |
| int_o | output | 1 | Byte-done flag, SCL held low while set |
| ack_o | output | 1 | Latched ninth-bit level |
| msel_o | output | 1 | Master mode indicator |
| busy_o | output | 1 | Transaction in progress |

## Verification
The bench builds the block with DIV_W=4 and sweeps div_i over 0, 1, 2 and 3. This brings the zero-divider boundary and several phase lengths within reach in a few thousand cycles. For each divider it applies all eight combinations of the three command values while the block waits. It predicts the outcome from the priority rules, then counts start conditions, stop conditions and bytes decoded from the bus by a passive monitor. A modelled slave alternates acknowledge and not-acknowledge, so ack_o is checked in both states.

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  input  logic             wr_i,
  input  logic             wr_int_i,
  input  logic             wr_start_i,
  input  logic             wr_msel_i,
  input  logic [7:0]       data_i,
  input  logic             sda_i,
  output logic             scl_o,
  output logic             sda_o,
  output logic             int_o,
  output logic             ack_o,
  output logic             msel_o,
  output logic             busy_o
);

  typedef enum logic [3:0] {
    IDLE, ST_HOLD, RS_REL, RS_HIGH, B_LO, B_HI, WAIT, SP_LO, SP_HI, SP_REL
  } st_t;

  st_t              st;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] dlen;
  logic [8:0]       sh;
  logic [3:0]       bitn;
  logic             ack_q, msel_q;

  assign dlen = (div_i == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : div_i;

  wire timed  = (st != IDLE) && (st != WAIT);
  wire ph_end = timed && (cnt == dlen - 1'b1);
  wire [8:0] load = {data_i, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      cnt    <= '0;
      sh     <= '1;
      bitn   <= '0;
      ack_q  <= 1'b0;
      msel_q <= 1'b0;
    end else begin
      cnt <= (timed && !ph_end) ? cnt + 1'b1 : '0;
      case (st)
        IDLE:
          if (wr_i && wr_msel_i) begin
            msel_q <= 1'b1;
            sh     <= load;
            st     <= ST_HOLD;
          end
        ST_HOLD:
          if (ph_end) begin
            bitn <= '0;
            st   <= B_LO;
          end
        RS_REL:  if (ph_end) st <= RS_HIGH;
        RS_HIGH: if (ph_end) st <= ST_HOLD;
        B_LO:    if (ph_end) st <= B_HI;
        B_HI:
          if (ph_end) begin
            if (bitn == 4'd8) begin
              ack_q <= sda_i;
              st    <= WAIT;
            end else begin
              bitn <= bitn + 1'b1;
              sh   <= {sh[7:0], 1'b1};
              st   <= B_LO;
            end
          end
        WAIT:
          if (wr_i) begin
            if (!wr_msel_i) begin
              msel_q <= 1'b0;
              st     <= SP_LO;
            end else if (wr_start_i) begin
              sh <= load;
              st <= RS_REL;
            end else if (!wr_int_i) begin
              sh   <= load;
              bitn <= '0;
              st   <= B_LO;
            end
          end
        SP_LO:   if (ph_end) st <= SP_HI;
        SP_HI:   if (ph_end) st <= SP_REL;
        SP_REL:  if (ph_end) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  assign scl_o = st inside {IDLE, ST_HOLD, RS_HIGH, B_HI, SP_HI, SP_REL};

  always_comb begin
    case (st)
      ST_HOLD, WAIT, SP_LO, SP_HI: sda_o = 1'b0;
      B_LO, B_HI:                  sda_o = sh[8];
      default:                     sda_o = 1'b1;
    endcase
  end

  assign int_o  = (st == WAIT);
  assign busy_o = (st != IDLE);
  assign ack_o  = ack_q;
  assign msel_o = msel_q;

  AST_SDA_ONLY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_o && $past(scl_o) && (sda_o != $past(sda_o))) |-> (st == ST_HOLD || st == SP_REL)); // R3
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WAIT && wr_i && !wr_msel_i) |=> (!msel_o && st == SP_LO)); // R8
  AST_RESTART_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WAIT && wr_i && wr_msel_i && wr_start_i) |=> (st == RS_REL)); // R7
  AST_NEXT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WAIT && wr_i && wr_msel_i && !wr_start_i && !wr_int_i) |=> (st == B_LO && bitn == 4'd0)); // R6
  AST_BUSY_TO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> ($past(st) == SP_REL)); // R12
  AST_PHASE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((st != $past(st)) && $past(st) != IDLE && $past(st) != WAIT) |-> ($past(cnt) == $past(dlen) - 1'b1)); // R11

endmodule

// File: tb/i2c_cmd_master_tb.sv
module i2c_cmd_master_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] div_i = 4'd1;
  logic       wr_i = 1'b0, wr_int_i = 1'b1, wr_start_i = 1'b0, wr_msel_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic       scl_o, sda_o, int_o, ack_o, msel_o, busy_o;
  logic       pull = 1'b0;
  logic       sda_line;

  int nchk = 0, nerr = 0;
  int nstart = 0, nstop = 0, nbyte = 0;
  int bits = 0, hicnt = 0, expd = 1;
  logic       bitpulse = 1'b0, nack = 1'b0;
  logic       ps = 1'b1, pd = 1'b1, cs, cd;
  logic [8:0] sh9 = '0;
  logic [7:0] last_byte = '0;
  logic       last_ack = 1'b0;

  always #4 clk = ~clk;

  assign sda_line = sda_o & ~pull;

  i2c_cmd_master #(.DIV_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .div_i(div_i), .wr_i(wr_i),
    .wr_int_i(wr_int_i), .wr_start_i(wr_start_i), .wr_msel_i(wr_msel_i),
    .data_i(data_i), .sda_i(sda_line), .scl_o(scl_o), .sda_o(sda_o),
    .int_o(int_o), .ack_o(ack_o), .msel_o(msel_o), .busy_o(busy_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    cs = scl_o;
    cd = sda_line;
    if (ps && cs) begin
      if (pd && !cd) begin nstart++; bits = 0; bitpulse = 1'b0; end
      else if (!pd && cd) begin nstop++; bits = 0; bitpulse = 1'b0; end
      if (bitpulse) hicnt++;
    end
    if (!ps && cs) begin
      sh9 = {sh9[7:0], cd};
      bits++;
      hicnt = 1;
      bitpulse = 1'b1;
    end
    if (ps && !cs) begin
      if (bitpulse) begin chk("R11 high phase", hicnt, expd); bitpulse = 1'b0; end
      if (bits == 8) pull = !nack;
      else if (bits == 9) begin
        pull = 1'b0;
        nbyte++;
        last_byte = sh9[8:1];
        last_ack = sh9[0];
        bits = 0;
      end
    end
    ps = cs;
    pd = cd;
  end

  task automatic wr(input logic i, input logic s, input logic m);
    wr_int_i = i; wr_start_i = s; wr_msel_i = m; wr_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic wait_int();
    int n = 0;
    while (!int_o && n < 3000) begin @(negedge clk); n++; end
    chk("R5 int raised", int_o, 1);
    @(negedge clk);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy_o && n < 3000) begin @(negedge clk); n++; end
    chk("R12 busy cleared", busy_o, 0);
    @(negedge clk);
  endtask

  task automatic open_txn(input logic [7:0] a);
    int s0 = nstart, b0 = nbyte;
    data_i = a;
    nack = 1'b0;
    wr(1'b1, 1'b0, 1'b1);
    chk("R2 msel set", msel_o, 1);
    chk("R12 busy set", busy_o, 1);
    wait_int();
    chk("R2 start seen", nstart, s0 + 1);
    chk("R2 byte count", nbyte, b0 + 1);
    chk("R2 address byte", last_byte, a);
    chk("R4 ack low", ack_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog (R5 R12): actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 scl", scl_o, 1); chk("R1 sda", sda_o, 1); chk("R1 int", int_o, 0);
    chk("R1 busy", busy_o, 0); chk("R1 msel", msel_o, 0); chk("R1 ack", ack_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset scl", scl_o, 1);

    wr(1'b0, 1'b1, 1'b0);
    repeat (10) @(negedge clk);
    chk("R10 slave write busy", busy_o, 0);
    chk("R10 slave write starts", nstart, 0);
    chk("R10 slave write msel", msel_o, 0);

    for (int d = 0; d <= 3; d++) begin
      div_i = d[3:0];
      expd = (d == 0) ? 1 : d;
      for (int c = 0; c < 8; c++) begin
        logic i, s, m;
        logic [7:0] val;
        int s0, p0, b0;
        i = c[2]; s = c[1]; m = c[0];
        if (!busy_o) open_txn(8'hA0 + 8'(c));
        val = 8'(8'h5A ^ (c * 37 + d * 11));
        data_i = val;
        nack = c[0] ^ d[0];
        s0 = nstart; p0 = nstop; b0 = nbyte;
        wr(i, s, m);
        if (!m) begin
          chk("R8 msel cleared", msel_o, 0);
          chk("R12 busy during stop", busy_o, 1);
          wait_idle();
          chk("R8 stop seen", nstop, p0 + 1);
          chk("R8 no start", nstart, s0);
          chk("R8 no byte", nbyte, b0);
          chk("R12 idle scl", scl_o, 1);
          chk("R12 idle sda", sda_o, 1);
        end else if (s) begin
          wait_int();
          chk("R7 restart seen", nstart, s0 + 1);
          chk("R7 no stop", nstop, p0);
          chk("R7 byte count", nbyte, b0 + 1);
          chk("R7 byte value", last_byte, val);
          chk("R3 ninth bit released", last_ack, nack);
          chk("R4 ack latched", ack_o, nack);
          chk("R5 scl held", scl_o, 0);
        end else if (!i) begin
          wait_int();
          chk("R6 no start", nstart, s0);
          chk("R6 no stop", nstop, p0);
          chk("R6 byte count", nbyte, b0 + 1);
          chk("R3 byte value", last_byte, val);
          chk("R4 ack latched", ack_o, nack);
        end else begin
          repeat (6 * expd + 4) @(negedge clk);
          chk("R9 int kept", int_o, 1);
          chk("R9 scl low", scl_o, 0);
          chk("R9 counts", nstart + nstop + nbyte, s0 + p0 + b0);
        end
      end
      if (busy_o) begin
        wr(1'b1, 1'b0, 1'b0);
        wait_idle();
      end
    end

    begin
      int p0;
      open_txn(8'h3C);
      data_i = 8'hC3;
      nack = 1'b0;
      wr(1'b0, 1'b0, 1'b1);
      repeat (3) @(negedge clk);
      p0 = nstop;
      wr(1'b0, 1'b0, 1'b0);
      wait_int();
      chk("R10 in-flight msel kept", msel_o, 1);
      chk("R10 in-flight no stop", nstop, p0);
      chk("R10 in-flight byte", last_byte, 8'hC3);
      wr(1'b1, 1'b0, 1'b0);
      wait_idle();
      chk("R8 final stop", nstop, p0 + 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule